// File: doc/BRIEF.md
# CORDIC Sine and Cosine Oscillator

This block is a numerically controlled oscillator. A 32-bit phase register advances once per enabled clock. The step is a centre-frequency word plus a signed correction, normally the output of a loop filter. The upper 16 bits of the updated phase form an angle, where a full turn is 2^16 codes. That angle is turned into a pair of 16-bit signed samples, sine and cosine. The conversion uses a pipeline of rotation-mode CORDIC stages, so no sine table is stored. Each output pair comes with a one-cycle valid strobe.

The first two angle bits fold the angle into the half turn centred on zero. This keeps the angle inside the range where the rotations converge, and the signs of the results are restored at the output. The rotation starts from a vector whose length is the reciprocal of the accumulated CORDIC gain. After the last stage the vector coordinates are therefore the scaled cosine and sine directly, and no multiplier is needed.

Precision is chosen by the number of rotation stages, which is a parameter. The per-stage angle constants are computed from the stage index, so changing the stage count rebuilds nothing by hand.

Top module: `nco_cordic_sine`

## Requirements
- R1: Synchronous active-high reset clears the phase to 0 and drives sin_o = 0, cos_o = 0, valid_o = 0.
- R2: On each clock with en_i = 1, the phase becomes (phase + fcw_i + sign-extended corr_i) mod 2^32. The angle of that sample is bits [31:16] of the new phase, and 0x10000 codes make one full turn.
- R3: While en_i = 0, the phase holds and no valid_o pulse is produced for those cycles.
- R4: Each enabled clock yields exactly one valid_o pulse, in issue order. The pulse is seen ITER+2 rising edges after the clock edge that accepted the enable, counting that edge as the first.
- R5: With the default 16 stages, sin_o and cos_o are within ±4 LSB of round(32000·sin(2π·a/65536)) and round(32000·cos(2π·a/65536)), where a is the sample's angle.
- R6: Signs are correct in all four quadrants, including the exact boundary angles 0x4000, 0x8000 and 0xC000. For angles in [0x4000, 0xBFFF], cos_o is not above +4.
- R7: With fcw_i = 0 and corr_i = 0, successive samples are identical.
- R8: A positive corr_i raises the phase step above fcw_i and a negative one lowers it. The step wraps modulo 2^32.
- R9: sin_o and cos_o keep their last values on cycles without valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance phase and issue one sample |
| fcw_i | input | 32 | Centre frequency word (phase step) |
| corr_i | input | 16 | Signed frequency correction, added to the step |
| sin_o | output | 16 | Signed sine sample |
| cos_o | output | 16 | Signed cosine sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The bench steps the angle in exact eighth-turn increments so that samples land on the quadrant boundaries. A wrong fold or a wrong sign restore there would flip a sine or cosine sign, or produce a half-turn error. It also issues the most positive and most negative corrections, with wrapping steps. A correction added without sign extension would make the phase run away, and that shows up as sample mismatches. Enables separated by idle gaps check the latency and that no extra strobe appears, which catches a pipeline valid bit that leaks or gets lost. A zero word checks that the output stays constant, and idle stretches check that the outputs hold between strobes.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Angle inside the rotator: a full turn is 2^ZW codes
    localparam int ZW      = 20;
    localparam int ANG_W   = 16;
    localparam int DATA_W  = 16;
    localparam int FRAC_G  = 4;                       // guard fraction bits in x/y
    localparam int XW      = DATA_W + FRAC_G + 1;     // headroom for gain growth
    localparam int AMP     = 32000;                   // nominal output amplitude
    localparam int SEED_16 = 19432;                   // AMP / gain(16 stages), rounded

    typedef logic signed [XW-1:0]     coord_t;
    typedef logic signed [ZW-1:0]     zang_t;
    typedef logic signed [DATA_W-1:0] sample_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        zang_t  z;
        logic   fold;
        logic   vld;
    } rot_beat_t;

    // arctan(2^-i) in units of 2^ZW per turn
    function automatic zang_t step_angle(input int i);
        int v;
        case (i)
            0:  v = 131072;
            1:  v = 77376;
            2:  v = 40884;
            3:  v = 20753;
            4:  v = 10417;
            5:  v = 5213;
            6:  v = 2607;
            7:  v = 1304;
            8:  v = 652;
            9:  v = 326;
            10: v = 163;
            11: v = 81;
            12: v = 41;
            13: v = 20;
            14: v = 10;
            15: v = 5;
            default: v = (166886 + (1 << (i - 1))) >>> i;
        endcase
        return zang_t'(v);
    endfunction

    function automatic sample_t clip_sample(input coord_t v);
        coord_t hi;
        coord_t lo;
        hi = coord_t'((1 <<< (DATA_W - 1)) - 1);
        lo = -hi;
        if (v > hi)      return sample_t'(hi);
        else if (v < lo) return sample_t'(lo);
        else             return sample_t'(v);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int CORR_W  = 16,
    parameter int OUT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic [PHASE_W-1:0]       fcw_i,
    input  logic signed [CORR_W-1:0] corr_i,
    output logic [OUT_W-1:0]         ang_nxt_o
);
    localparam int EXT_W = PHASE_W - CORR_W;

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] step;
    logic [PHASE_W-1:0] acc_nxt;

    always_comb begin
        step    = fcw_i + {{EXT_W{corr_i[CORR_W-1]}}, corr_i};
        acc_nxt = acc_q + step;
    end

    assign ang_nxt_o = acc_nxt[PHASE_W-1 -: OUT_W];

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (en_i) acc_q <= acc_nxt;
    end

    // R3: phase frozen while disabled
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> acc_q == $past(acc_q));

endmodule

// File: rtl/nco_rot_stage.sv
module nco_rot_stage
    import nco_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  rot_beat_t beat_i,
    output rot_beat_t beat_o
);
    localparam zang_t ANG = step_angle(IDX);

    rot_beat_t nxt;
    coord_t    xs;
    coord_t    ys;

    always_comb begin
        xs  = beat_i.x >>> IDX;
        ys  = beat_i.y >>> IDX;
        nxt = beat_i;
        if (!beat_i.z[ZW-1]) begin
            nxt.x = beat_i.x - ys;
            nxt.y = beat_i.y + xs;
            nxt.z = beat_i.z - ANG;
        end else begin
            nxt.x = beat_i.x + ys;
            nxt.y = beat_i.y - xs;
            nxt.z = beat_i.z + ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o <= nxt;
        end
    end

endmodule

// File: rtl/nco_rot_pipe.sv
module nco_rot_pipe
    import nco_pkg::*;
#(
    parameter int ITER = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  rot_beat_t beat_i,
    output coord_t    x_o,
    output coord_t    y_o,
    output logic      fold_o,
    output logic      vld_o
);
    rot_beat_t chain [ITER+1];

    assign chain[0] = beat_i;

    for (genvar g = 0; g < ITER; g++) begin : g_stage
        nco_rot_stage #(.IDX(g)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .beat_i (chain[g]),
            .beat_o (chain[g+1])
        );
    end

    assign x_o    = chain[ITER].x;
    assign y_o    = chain[ITER].y;
    assign fold_o = chain[ITER].fold;
    assign vld_o  = chain[ITER].vld;

    localparam zang_t RES_BOUND = zang_t'(2 * step_angle(ITER - 1) + 16);

    // R5: residual angle driven to near zero by the last stage
    a_r5_residual_small: assert property (@(posedge clk) disable iff (rst)
        chain[ITER].vld |-> (chain[ITER].z <= RES_BOUND && chain[ITER].z >= -RES_BOUND));

endmodule

// File: rtl/nco_cordic_sine.sv
module nco_cordic_sine
    import nco_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int CORR_W  = 16,
    parameter int ITER    = 16,
    parameter int SEED    = SEED_16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_i,
    input  logic [PHASE_W-1:0]       fcw_i,
    input  logic signed [CORR_W-1:0] corr_i,
    output logic signed [DATA_W-1:0] sin_o,
    output logic signed [DATA_W-1:0] cos_o,
    output logic                     valid_o
);
    localparam int    ZSHIFT = ZW - ANG_W;
    localparam coord_t X0    = coord_t'(SEED) <<< FRAC_G;
    localparam coord_t RND   = coord_t'(1) <<< (FRAC_G - 1);

    logic [ANG_W-1:0] ang;
    logic             fold;
    logic [ANG_W-1:0] ang_f;
    rot_beat_t        seed_q;

    nco_phase_acc #(
        .PHASE_W (PHASE_W),
        .CORR_W  (CORR_W),
        .OUT_W   (ANG_W)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .fcw_i     (fcw_i),
        .corr_i    (corr_i),
        .ang_nxt_o (ang)
    );

    // Fold quadrants 1 and 2 onto 3 and 0 by a half-turn shift
    always_comb begin
        fold  = ang[ANG_W-1] ^ ang[ANG_W-2];
        ang_f = fold ? (ang ^ (ANG_W'(1) << (ANG_W - 1))) : ang;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q <= '0;
        end else begin
            seed_q.x    <= X0;
            seed_q.y    <= '0;
            seed_q.z    <= zang_t'(signed'(ang_f)) <<< ZSHIFT;
            seed_q.fold <= fold;
            seed_q.vld  <= en_i;
        end
    end

    coord_t px;
    coord_t py;
    logic   pfold;
    logic   pvld;

    nco_rot_pipe #(.ITER(ITER)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .beat_i (seed_q),
        .x_o    (px),
        .y_o    (py),
        .fold_o (pfold),
        .vld_o  (pvld)
    );

    coord_t rx;
    coord_t ry;
    logic   fold_q;

    always_comb begin
        rx = (px + RND) >>> FRAC_G;
        ry = (py + RND) >>> FRAC_G;
        if (pfold) begin
            rx = -rx;
            ry = -ry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o   <= '0;
            cos_o   <= '0;
            valid_o <= 1'b0;
            fold_q  <= 1'b0;
        end else begin
            valid_o <= pvld;
            if (pvld) begin
                sin_o  <= clip_sample(ry);
                cos_o  <= clip_sample(rx);
                fold_q <= pfold;
            end
        end
    end

    localparam longint RLO = longint'(AMP - 8) * longint'(AMP - 8);
    localparam longint RHI = longint'(AMP + 8) * longint'(AMP + 8);

    // R5: output vector length stays near the nominal amplitude
    a_r5_radius: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o) >= RLO &&
                     longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o) <= RHI));

    // R6: folded angles lie in the left half plane
    a_r6_fold_sign: assert property (@(posedge clk) disable iff (rst)
        valid_o && fold_q |-> cos_o <= 4);

    // R6: unfolded angles lie in the right half plane
    a_r6_unfold_sign: assert property (@(posedge clk) disable iff (rst)
        valid_o && !fold_q |-> cos_o >= -4);

    // R9: outputs only move with a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o && !$past(rst) |-> $stable(sin_o) && $stable(cos_o));

endmodule

// File: tb/nco_cordic_sine_test.sv
module nco_cordic_sine_test;

    localparam int ITER = 16;
    localparam int LAT  = ITER + 2;
    localparam int TOL  = 4;
    localparam real PI  = 3.141592653589793;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en_i = 1'b0;
    logic [31:0]        fcw_i = '0;
    logic signed [15:0] corr_i = '0;
    logic signed [15:0] sin_o;
    logic signed [15:0] cos_o;
    logic               valid_o;

    nco_cordic_sine #(.ITER(ITER)) uut (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .fcw_i   (fcw_i),
        .corr_i  (corr_i),
        .sin_o   (sin_o),
        .cos_o   (cos_o),
        .valid_o (valid_o)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    logic [31:0] model_acc = '0;

    int    q_s[$];
    int    q_c[$];
    int    q_t[$];
    string q_g[$];

    int    prev_s = 0;
    int    prev_c = 0;
    bit    have_prev = 1'b0;
    int    nvalid = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one enabled cycle, expected result pushed to the scoreboard
    task automatic issue(input logic [31:0] fcw, input logic signed [15:0] corr,
                         input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            en_i   = 1'b1;
            fcw_i  = fcw;
            corr_i = corr;
            model_acc = model_acc + fcw + {{16{corr[15]}}, corr};
            begin
                real a;
                a = 2.0 * PI * real'(model_acc[31:16]) / 65536.0;
                q_s.push_back(rnd(32000.0 * $sin(a)));
                q_c.push_back(rnd(32000.0 * $cos(a)));
                q_t.push_back(cyc);
                q_g.push_back(tag);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            en_i = 1'b0;
            fcw_i = 32'hDEAD_BEEF;
            corr_i = 16'sh1234;
        end
    endtask

    // Monitor: compare each produced sample with the queue head
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            nvalid++;
            if (q_s.size() == 0) begin
                check(1'b0, "R3", "unexpected valid", 1, 0);
            end else begin
                int es;
                int ec;
                int et;
                string tg;
                es = q_s.pop_front();
                ec = q_c.pop_front();
                et = q_t.pop_front();
                tg = q_g.pop_front();
                check((sin_o - es <= TOL) && (es - sin_o <= TOL), tg, "sine", sin_o, es);
                check((cos_o - ec <= TOL) && (ec - cos_o <= TOL), tg, "cosine", cos_o, ec);
                check(cyc - et == LAT, "R4", "latency", cyc - et, LAT);
                if (tg == "R7" && have_prev) begin
                    check(sin_o == prev_s, "R7", "constant sine", sin_o, prev_s);
                    check(cos_o == prev_c, "R7", "constant cosine", cos_o, prev_c);
                end
                prev_s = sin_o;
                prev_c = cos_o;
                have_prev = 1'b1;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(sin_o == 0, "R1", "sine after reset", sin_o, 0);
        check(cos_o == 0, "R1", "cosine after reset", cos_o, 0);
        check(valid_o == 0, "R1", "valid after reset", valid_o, 0);

        // R3: idle with busy-looking inputs produces nothing and keeps phase
        idle(30);
        check(nvalid == 0, "R3", "strobes while idle", nvalid, 0);

        // R6: eighth-turn steps land on every quadrant boundary
        issue(32'h2000_0000, 16'sh0000, 16, "R6");
        idle(LAT + 2);

        // R2 / R5: irregular step across many angles
        issue(32'h0131_3B13, 16'sh0000, 100, "R5");

        // R8: extreme positive and negative corrections, wrapping
        issue(32'h0100_0000, 16'sh7FFF, 30, "R8");
        issue(32'h0000_0000, -16'sh8000, 30, "R8");
        issue(32'hFFFF_F000, 16'sh7FFF, 20, "R8");

        // R7: zero step holds the sample
        issue(32'h0000_0000, 16'sh0000, 20, "R7");
        idle(LAT + 2);
        have_prev = 1'b0;

        // R3 / R4: isolated enables separated by gaps
        for (int k = 0; k < 20; k++) begin
            issue(32'h0777_1234 + 32'(k) * 32'h0100_0000, 16'(k * 97 - 900), 1, "R2");
            idle(k % 3 + 1);
        end
        idle(LAT + 4);

        // R9: outputs hold without strobes
        begin
            int hs;
            int hc;
            int nv;
            hs = sin_o;
            hc = cos_o;
            nv = nvalid;
            idle(12);
            check(sin_o == hs, "R9", "sine held", sin_o, hs);
            check(cos_o == hc, "R9", "cosine held", cos_o, hc);
            check(nvalid == nv, "R3", "no strobe while idle", nvalid, nv);
        end

        check(q_s.size() == 0, "R4", "samples missing", q_s.size(), 0);
        finish_run();
    end

endmodule